// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests for an 8-bit processor core and turns them into one vectored request at a time. It serves eight sources: four external pins, two timer overflows, a serial port and a third timer. Each source has an enable bit and a two-bit priority level. A global enable gates all eight sources. The controller keeps one in-service bit per level. A routine that is running can therefore be interrupted only by a request at a strictly higher level.

The CPU sees a registered request with an 8-bit vector and answers with an acknowledge pulse. When a routine ends, the CPU pulses a return strobe, which closes the innermost active level. Flags are kept in software-visible registers, and each source has its own rule for clearing its flag when the vector is taken. The external pins can each be used in level or falling-edge mode.

Top module: `irq_ctrl`

## Requirements
- R1: While the global enable (register 1, bit 0) is 0, no new request is raised, whatever flags are pending.
- R2: Source i can raise a request only while its enable bit (register 0, bit i) is 1.
- R3: The level of source i is {register 3 bit i, register 2 bit i}, from 0 (lowest) to 3. Among the eligible pending sources, the one with the highest level wins.
- R4: Among pending sources at the same level, the lowest index wins. The indices are: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 ext2, 7 ext3.
- R5: The vector is 8'h03 + 8*index.
- R6: An acknowledge marks the granted level as in service, and a return strobe clears only the highest in-service level. A request is granted only if its level is strictly above every level in service, so an equal or lower level never preempts.
- R7: Each external pin is active low, and its mode bit is in register 4 (bit k for ext k, 1 = edge). In level mode the flag equals the inverted pin. In edge mode the flag is set when a high sample is followed by a low sample on the next clock.
- R8: Taking a vector clears the flag of an edge-mode external source or of a timer0/timer1 source. It leaves level-mode external flags, serial flags and timer2 flags unchanged.
- R9: The serial request is the OR of the receive flag (register 5, bit 4) and the transmit flag (register 6, bit 0). The timer2 request is the OR of its overflow flag (register 5, bit 5) and its external flag (register 6, bit 1).
- R10: A write to register 5 (bit i is the main flag of source i) or to register 6 sets and clears the flags like hardware does. A hardware set in the same cycle as a vector clear or a write leaves the flag set.
- R11: A request raised by a flag at one clock edge appears on irq_req_o after the next edge. The request and vector then hold steady until acknowledged, and the request drops at the acknowledging edge.
- R12: Registers 0 to 6 read back what was written, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 4 | External request pins, active low |
| tmr_ovf_i | input | 2 | Timer0/timer1 overflow set pulses |
| ser_set_i | input | 2 | Serial receive (bit 0) / transmit (bit 1) set pulses |
| t2_set_i | input | 2 | Timer2 overflow (bit 0) / external (bit 1) set pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_req_o | output | 1 | Interrupt request to CPU |
| irq_vec_o | output | 8 | Vector address |
| irq_ack_i | input | 1 | CPU acknowledge |
| irq_reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
Two pairs of events can land on the same edge. A hardware flag set can coincide with the vector clear of that same source. Separately, a higher-level source can become pending while an earlier request is still held for acknowledge. The bench provokes the first by pulsing a timer overflow together with the acknowledge, and then expects the flag to read back as set. It provokes the second by raising a level-2 request under a held level-0 request. It expects the held vector to stay unchanged until the acknowledge and the new vector to follow one edge later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 8;
  localparam int LVLW = 2;
  localparam int NLVL = 1 << LVLW;
  localparam int SIW  = $clog2(NSRC);
  localparam int DW   = 8;
  localparam int AW   = 3;
  localparam int NEXT = 4;
  localparam logic [DW-1:0] VEC_BASE = 8'h03;

  typedef enum logic [AW-1:0] {
    A_EN = 3'd0, A_GIE = 3'd1, A_PLO = 3'd2, A_PHI = 3'd3,
    A_TRIG = 3'd4, A_FLAG = 3'd5, A_AUX = 3'd6
  } reg_addr_e;

  // source index -> external pin slot, -1 when not external
  function automatic int ext_slot(int s);
    case (s)
      0: return 0;
      2: return 1;
      6: return 2;
      7: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_timer(int s);
    return (s == 1) || (s == 3);
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] ext_n_i,
  input  logic [NEXT-1:0] edge_mode_i,
  input  logic [NSRC-1:0] hw_set_i,
  input  logic [1:0]      aux_set_i,
  input  logic            wr_main_i,
  input  logic            wr_aux_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] vec_clr_i,
  output logic [NSRC-1:0] flag_o,
  output logic [1:0]      aux_o,
  output logic [NSRC-1:0] pend_o
);
  logic [NEXT-1:0] pin_q;
  logic [NSRC-1:0] flag_q, flag_d;
  logic [1:0]      aux_q, aux_d;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int XS = ext_slot(s);
    logic base;
    assign base = wr_main_i ? wdata_i[s] : flag_q[s];
    if (XS >= 0) begin : g_ext
      assign flag_d[s] = !edge_mode_i[XS] ? ~ext_n_i[XS]
                       : ((base & ~vec_clr_i[s]) | (pin_q[XS] & ~ext_n_i[XS]));
    end else if (is_timer(s)) begin : g_tmr
      assign flag_d[s] = (base & ~vec_clr_i[s]) | hw_set_i[s];
    end else begin : g_keep
      assign flag_d[s] = base | hw_set_i[s];
    end
  end

  assign aux_d = (wr_aux_i ? wdata_i[1:0] : aux_q) | aux_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= '1;
      flag_q <= '0;
      aux_q  <= '0;
    end else begin
      pin_q  <= ext_n_i;
      flag_q <= flag_d;
      aux_q  <= aux_d;
    end
  end

  assign flag_o = flag_q;
  assign aux_o  = aux_q;
  // serial and timer2 requests merge their second flag
  assign pend_o = flag_q | {2'b00, aux_q, 4'b0000};

  // R8
  tmr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_clr_i[1] && !hw_set_i[1] |=> !flag_q[1]);
  // R8
  ser_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_clr_i[4] && flag_q[4] && !wr_main_i |=> flag_q[4]);
  // R10
  hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i[3] |=> flag_q[3]);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]           pend_i,
  input  logic [NSRC-1:0][LVLW-1:0] lvl_i,
  input  logic [NLVL-1:0]           isr_i,
  output logic                      grant_o,
  output logic [SIW-1:0]            idx_o,
  output logic [LVLW-1:0]           lvl_o
);
  logic            found, busy;
  logic [LVLW-1:0] top;

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    // descending scan with >= leaves the lowest index on ties
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (!found || lvl_i[i] >= lvl_o)) begin
        found = 1'b1;
        lvl_o = lvl_i[i];
        idx_o = i[SIW-1:0];
      end
    end
    busy = 1'b0;
    top  = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_i[l]) begin
        busy = 1'b1;
        top  = l[LVLW-1:0];
      end
    end
    grant_o = found && (!busy || lvl_o > top);
  end
endmodule

// File: rtl/irq_inserv.sv
module irq_inserv
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [LVLW-1:0] set_lvl_i,
  input  logic            reti_i,
  output logic [NLVL-1:0] isr_o
);
  logic [NLVL-1:0] isr_q, drop, set_m;
  logic            hit;

  always_comb begin
    drop = '0;
    hit  = 1'b0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (isr_q[l] && !hit) begin
        drop[l] = 1'b1;
        hit     = 1'b1;
      end
    end
    set_m = set_i ? ({{(NLVL-1){1'b0}}, 1'b1} << set_lvl_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (reti_i ? (isr_q & ~drop) : isr_q) | set_m;
  end

  assign isr_o = isr_q;

  // R6
  reti_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !set_i && (isr_q != '0) |=> $countones(isr_q) + 1 == $countones($past(isr_q)));
  // R6
  ack_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> isr_q[$past(set_lvl_i)]);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] ext_n_i,
  input  logic [1:0]      tmr_ovf_i,
  input  logic [1:0]      ser_set_i,
  input  logic [1:0]      t2_set_i,
  input  logic            reg_wr_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_req_o,
  output logic [DW-1:0]   irq_vec_o,
  input  logic            irq_ack_i,
  input  logic            irq_reti_i
);
  logic [NSRC-1:0] en_q, plo_q, phi_q;
  logic            gie_q;
  logic [NEXT-1:0] trig_q;

  logic [NSRC-1:0]           flags, pend, hw_set, vec_clr;
  logic [1:0]                aux;
  logic [NSRC-1:0][LVLW-1:0] lvl;
  logic [NLVL-1:0]           isr;
  logic                      grant, ack;
  logic [SIW-1:0]            win_idx, src_q;
  logic [LVLW-1:0]           win_lvl, lvl_q;
  logic                      req_q;
  logic [DW-1:0]             vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0; gie_q <= 1'b0; plo_q <= '0; phi_q <= '0; trig_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_EN:    en_q   <= reg_wdata_i;
        A_GIE:   gie_q  <= reg_wdata_i[0];
        A_PLO:   plo_q  <= reg_wdata_i;
        A_PHI:   phi_q  <= reg_wdata_i;
        A_TRIG:  trig_q <= reg_wdata_i[NEXT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_EN:    reg_rdata_o = en_q;
      A_GIE:   reg_rdata_o = {{(DW-1){1'b0}}, gie_q};
      A_PLO:   reg_rdata_o = plo_q;
      A_PHI:   reg_rdata_o = phi_q;
      A_TRIG:  reg_rdata_o = {{(DW-NEXT){1'b0}}, trig_q};
      A_FLAG:  reg_rdata_o = flags;
      A_AUX:   reg_rdata_o = {{(DW-2){1'b0}}, aux};
      default: reg_rdata_o = '0;
    endcase
  end

  assign hw_set = {2'b00, t2_set_i[0], ser_set_i[0], tmr_ovf_i[1], 1'b0, tmr_ovf_i[0], 1'b0};
  assign ack    = req_q & irq_ack_i;
  assign vec_clr = ack ? ({{(NSRC-1){1'b0}}, 1'b1} << src_q) : '0;

  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    assign lvl[s] = {phi_q[s], plo_q[s]};
  end

  irq_flags u_flags (
    .clk_i, .rst_ni,
    .ext_n_i, .edge_mode_i(trig_q),
    .hw_set_i(hw_set), .aux_set_i({t2_set_i[1], ser_set_i[1]}),
    .wr_main_i(reg_wr_i && reg_addr_i == A_FLAG),
    .wr_aux_i(reg_wr_i && reg_addr_i == A_AUX),
    .wdata_i(reg_wdata_i), .vec_clr_i(vec_clr),
    .flag_o(flags), .aux_o(aux), .pend_o(pend)
  );

  irq_arb u_arb (
    .pend_i(pend & en_q & {NSRC{gie_q}}), .lvl_i(lvl), .isr_i(isr),
    .grant_o(grant), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  irq_inserv u_isr (
    .clk_i, .rst_ni, .set_i(ack), .set_lvl_i(lvl_q),
    .reti_i(irq_reti_i), .isr_o(isr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; src_q <= '0; lvl_q <= '0; vec_q <= '0;
    end else if (ack) begin
      req_q <= 1'b0;
    end else if (!req_q && grant) begin
      req_q <= 1'b1;
      src_q <= win_idx;
      lvl_q <= win_lvl;
      vec_q <= VEC_BASE + {{(DW-SIW-3){1'b0}}, win_idx, 3'b000};
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !irq_ack_i |=> req_q && $stable(vec_q));
  // R5
  vec_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> vec_q[2:0] == 3'b011);
  // R6
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> (({{(NLVL-1){1'b0}}, 1'b1} << lvl_q) > $past(isr)));
  // R1
  gie_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q && !req_q |=> !req_q);
  // R2
  en_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) && !req_q |=> !req_q);
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] ext_n = '1;
  logic [1:0] tmr_ovf = '0, ser_set = '0, t2_set = '0;
  logic       reg_wr = 0, irq_ack = 0, irq_reti = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, irq_vec;
  logic       irq_req;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_n_i(ext_n), .tmr_ovf_i(tmr_ovf),
    .ser_set_i(ser_set), .t2_set_i(t2_set), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_ack_i(irq_ack),
    .irq_reti_i(irq_reti)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = a[2:0]; reg_wdata = d[7:0]; tick(); reg_wr = 0;
  endtask
  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = a[2:0]; #1; d = reg_rdata;
  endtask
  task automatic ack(); irq_ack = 1; tick(); irq_ack = 0; endtask
  task automatic reti(); irq_reti = 1; tick(); irq_reti = 0; endtask
  task automatic reset();
    rst_n = 0; ext_n = '1; tmr_ovf = '0; ser_set = '0; t2_set = '0;
    reg_wr = 0; irq_ack = 0; irq_reti = 0;
    tick(); tick(); rst_n = 1; tick();
  endtask
  task automatic setup(input int en, input int plo, input int phi, input int trig);
    wr(0, en); wr(2, plo); wr(3, phi); wr(4, trig); wr(1, 1);
  endtask
  function automatic int vec_of(input int s); return 3 + 8 * s; endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    reset();
    chk("R11 reset req", irq_req, 0);
    rd(0, rv); chk("R12 reset en", rv, 0);
    rd(5, rv); chk("R12 reset flags", rv, 0);

    // register readback
    wr(0, 8'hA5); rd(0, rv); chk("R12 en readback", rv, 8'hA5);
    wr(4, 8'hFF); rd(4, rv); chk("R12 trig readback", rv, 8'h0F);
    wr(6, 8'hFF); rd(6, rv); chk("R12 aux readback", rv, 8'h03);

    // R5 R3 R8: every source at every level, software-raised
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 4; l++) begin
        reset();
        setup(1 << s, (l & 1) ? (1 << s) : 0, (l & 2) ? (1 << s) : 0, 4'hF);
        wr(5, 1 << s); tick();
        chk("R5 req", irq_req, 1);
        chk("R5 vector", irq_vec, vec_of(s));
        ack();
        chk("R11 req drop", irq_req, 0);
        rd(5, rv);
        chk("R8 clear rule", rv[s], (s == 4 || s == 5) ? 1 : 0);
      end
    end

    // R4: same-level pairs, lower index wins
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        reset();
        setup(8'hFF, 8'h00, 8'hFF, 4'hF);
        wr(5, (1 << i) | (1 << j)); tick();
        chk("R4 poll order", irq_vec, vec_of(i));
      end
    end

    // R3: higher level beats polling order
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        reset();
        setup(8'hFF, 1 << i, 1 << j, 4'hF);
        wr(5, (1 << i) | (1 << j)); tick();
        chk("R3 level wins", irq_vec, vec_of(j));
      end
    end

    // R1 global enable
    reset();
    wr(0, 8'hFF); wr(5, 8'h02); tick(); tick();
    chk("R1 masked", irq_req, 0);
    wr(1, 1); tick();
    chk("R1 unmasked req", irq_req, 1);
    chk("R1 unmasked vec", irq_vec, 8'h0B);

    // R2 individual enable
    reset();
    setup(8'hFD, 0, 0, 4'hF);
    wr(5, 8'h02); tick(); tick();
    chk("R2 disabled", irq_req, 0);
    wr(0, 8'hFF); tick();
    chk("R2 enabled", irq_req, 1);

    // R6 nesting: src3 L1, src0 L1, src5 L0, src2 L2
    reset();
    setup(8'hFF, 8'h09, 8'h04, 4'hF);
    wr(5, 8'h08); tick();
    chk("R6 first vec", irq_vec, 8'h1B);
    ack();
    wr(5, 8'h21); tick(); tick();
    chk("R6 equal/lower blocked", irq_req, 0);
    wr(5, 8'h25); tick();
    chk("R6 higher preempts", irq_vec, 8'h13);
    chk("R6 higher req", irq_req, 1);
    ack(); tick();
    chk("R6 nested busy", irq_req, 0);
    reti(); tick();
    chk("R6 inner return keeps L1", irq_req, 0);
    reti(); tick();
    chk("R6 outer return vec", irq_vec, 8'h03);
    ack(); tick();
    chk("R6 L0 blocked under L1", irq_req, 0);
    reti(); tick();
    chk("R6 L0 after return", irq_vec, 8'h2B);

    // R7 edge mode on ext1 (src2)
    reset();
    setup(8'hFF, 0, 0, 4'b0010);
    ext_n[1] = 0; tick(); tick();
    chk("R7 edge req", irq_req, 1);
    chk("R7 edge vec", irq_vec, 8'h13);
    ack(); tick(); tick();
    chk("R7 no re-trigger while low", irq_req, 0);
    rd(5, rv); chk("R8 edge flag cleared", rv[2], 0);
    reti(); ext_n[1] = 1;

    // R7 level mode on ext3 (src7)
    wr(4, 0);
    ext_n[3] = 0; tick(); tick();
    chk("R7 level vec", irq_vec, 8'h3B);
    ack();
    rd(5, rv); chk("R8 level flag kept", rv[7], 1);
    reti(); tick();
    chk("R7 level re-requests", irq_req, 1);
    ack();
    ext_n[3] = 1; tick();
    rd(5, rv); chk("R7 level follows pin", rv[7], 0);

    // R9 serial transmit flag and timer2 external flag
    reset();
    setup(8'hFF, 0, 0, 4'hF);
    wr(6, 8'h01); tick();
    chk("R9 serial OR vec", irq_vec, 8'h23);
    ack();
    rd(6, rv); chk("R8 serial aux kept", rv[0], 1);
    reset();
    setup(8'hFF, 0, 0, 4'hF);
    t2_set = 2'b10; tick(); t2_set = 0; tick();
    chk("R9 timer2 OR vec", irq_vec, 8'h2B);

    // R10 hardware set coinciding with vector clear
    reset();
    setup(8'hFF, 0, 0, 4'hF);
    wr(5, 8'h02); tick();
    chk("R10 timer0 vec", irq_vec, 8'h0B);
    irq_ack = 1; tmr_ovf = 2'b01; tick(); irq_ack = 0; tmr_ovf = 0;
    rd(5, rv); chk("R10 set beats clear", rv[1], 1);
    wr(5, 0); rd(5, rv); chk("R10 software clear", rv[1], 0);
    tmr_ovf = 2'b10; tick(); tmr_ovf = 0;
    rd(5, rv); chk("R10 timer1 hw set", rv[3], 1);

    // R11 held request stays stable while higher level arrives
    reset();
    setup(8'hFF, 0, 0, 4'hF);
    wr(5, 8'h80); tick();
    chk("R11 held vec", irq_vec, 8'h3B);
    wr(3, 8'h01); wr(5, 8'h81); tick(); tick();
    chk("R11 vec stable", irq_vec, 8'h3B);
    chk("R11 req stable", irq_req, 1);
    ack();
    chk("R11 drop on ack", irq_req, 0);
    tick();
    chk("R11 next vec", irq_vec, 8'h03);
    chk("R11 next req", irq_req, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule